// File: doc/BRIEF.md
# Host/DSP Shared Resource Access Arbiter

This block stands between a signal processor's local resources and the two agents that want to use them: an external host port and the local DSP. It routes every request to one of two target ports, a shared-memory port (split by address into SARAM, DARAM and external regions) or a public peripheral port. It decides who gets each target according to a two-bit access mode that only the DSP can write.

The memory bit and the peripheral bit act independently, which gives four modes. With both bits clear, memory and peripherals are shared, and a tie on the same target is broken round-robin. With the memory bit set, the host owns SARAM exclusively. In that case the host cannot reach DARAM or external memory, while the DSP keeps DARAM and external memory. With the peripheral bit set, the host owns the peripheral port exclusively.

Every transfer is started by its requester and held until the block answers with a one-cycle ready. A new mode is staged and applied only once no access is in flight.

Top module: `host_access_arbiter`

## Requirements
- R1: Address decode: bit 15 set selects the peripheral port. Otherwise bits 14:13 pick the memory region: 00 SARAM, 01 DARAM, 10 or 11 external. `mem_region_o` reports 0 for SARAM, 1 for DARAM and 2 for external.
- R2: Handshake:
  - A requester holds req, we, addr and wdata stable until its ready is high for one cycle, and drops req in the following cycle.
  - A target request is held with a stable address until ack.
  - Ready appears in the same cycle as the target ack.
  - An uncontended access with an immediate ack completes in the cycle after the request is first seen.
- R3: When both agents request the same target in the same cycle and both may use it, the grant alternates round-robin. The host wins the first tie after reset.
- R4: `mode_we_i` writes `mode_wdata_i`, where bit 1 is host-only memory and bit 0 is host-only peripheral. The written value appears on `mode_o` two cycles after the write when nothing is in flight. Reset value is 00.
- R5: In host-only memory mode the host is serviced on SARAM. A DSP request to SARAM is stalled with no ready. DSP requests to DARAM and external memory are still serviced.
- R6: In host-only memory mode a host request to DARAM or external memory gets `host_err_o` together with `host_ready_o` one cycle after the request. No memory target access takes place, and the stored data is left unchanged.
- R7: In host-only peripheral mode DSP peripheral requests are stalled. Host peripheral requests are serviced.
- R8: A mode write does not take effect while an access is in flight. No new grant is made while a mode change is pending.
- R9: Read data returned to a requester comes from the target that serviced its access. Write data reaches that target at the decoded region and offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host request |
| host_we_i | input | 1 | Host write enable |
| host_addr_i | input | AW | Host address |
| host_wdata_i | input | DW | Host write data |
| host_rdata_o | output | DW | Host read data |
| host_ready_o | output | 1 | Host access complete |
| host_err_o | output | 1 | Host access refused by mode |
| dsp_req_i | input | 1 | DSP request |
| dsp_we_i | input | 1 | DSP write enable |
| dsp_addr_i | input | AW | DSP address |
| dsp_wdata_i | input | DW | DSP write data |
| dsp_rdata_o | output | DW | DSP read data |
| dsp_ready_o | output | 1 | DSP access complete |
| mode_we_i | input | 1 | DSP mode write strobe |
| mode_wdata_i | input | 2 | {host-only memory, host-only peripheral} |
| mode_o | output | 2 | Active mode |
| mem_req_o | output | 1 | Memory target request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory address |
| mem_region_o | output | 2 | Decoded memory region |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data |
| mem_ack_i | input | 1 | Memory access done |
| per_req_o | output | 1 | Peripheral target request |
| per_we_o | output | 1 | Peripheral write enable |
| per_addr_o | output | AW | Peripheral address |
| per_wdata_o | output | DW | Peripheral write data |
| per_rdata_i | input | DW | Peripheral read data |
| per_ack_i | input | 1 | Peripheral access done |

## Verification
Directed cases cover four things:
- The region decode, with one address per region and the write landing in the matching store.
- Simultaneous requests before and after a lone host access, which separates a fixed priority from true alternation.
- Each exclusive mode, with the refused side shown to stall or to error without touching storage.
- A mode write issued while a stalled access is in flight, which shows whether the change waits.

A seeded random phase then runs host and DSP traffic concurrently with random ack delays over all targets. Read-back compared to a bench shadow copy catches misrouted data and lost or duplicated grants.

// File: rtl/hma_pkg.sv
package hma_pkg;
  typedef enum logic {OWN_HOST = 1'b0, OWN_DSP = 1'b1} owner_e;
  typedef enum logic [1:0] {RGN_SARAM = 2'd0, RGN_DARAM = 2'd1, RGN_EXT = 2'd2} region_e;

  function automatic region_e rgn_of(input logic [1:0] bits);
    case (bits)
      2'b00:   return RGN_SARAM;
      2'b01:   return RGN_DARAM;
      default: return RGN_EXT;
    endcase
  endfunction
endpackage

// File: rtl/hma_slot.sv
// One target port: two-way round-robin grant, held until target ack.
module hma_slot
  import hma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          h_req_i,
  input  logic          h_we_i,
  input  logic [AW-1:0] h_addr_i,
  input  logic [DW-1:0] h_wdata_i,
  input  logic          d_req_i,
  input  logic          d_we_i,
  input  logic [AW-1:0] d_addr_i,
  input  logic [DW-1:0] d_wdata_i,
  output logic          tgt_req_o,
  output logic          tgt_we_o,
  output logic [AW-1:0] tgt_addr_o,
  output logic [DW-1:0] tgt_wdata_o,
  input  logic          tgt_ack_i,
  output logic          h_done_o,
  output logic          d_done_o,
  output logic          busy_o,
  output owner_e        owner_o
);
  logic   busy_q, grant;
  owner_e owner_q, last_q, win;

  always_comb begin
    if (h_req_i && d_req_i) win = (last_q == OWN_HOST) ? OWN_DSP : OWN_HOST;
    else if (d_req_i)       win = OWN_DSP;
    else                    win = OWN_HOST;
    grant = !busy_q && !hold_i && (h_req_i || d_req_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      owner_q <= OWN_HOST;
      last_q  <= OWN_DSP;  // host takes the first tie
    end else if (grant) begin
      busy_q  <= 1'b1;
      owner_q <= win;
      last_q  <= win;
    end else if (busy_q && tgt_ack_i) begin
      busy_q  <= 1'b0;
    end
  end

  always_comb begin
    tgt_req_o   = busy_q;
    tgt_we_o    = (owner_q == OWN_DSP) ? d_we_i    : h_we_i;
    tgt_addr_o  = (owner_q == OWN_DSP) ? d_addr_i  : h_addr_i;
    tgt_wdata_o = (owner_q == OWN_DSP) ? d_wdata_i : h_wdata_i;
    h_done_o    = busy_q && tgt_ack_i && (owner_q == OWN_HOST);
    d_done_o    = busy_q && tgt_ack_i && (owner_q == OWN_DSP);
  end

  assign busy_o  = busy_q;
  assign owner_o = owner_q;
endmodule

// File: rtl/hma_mode.sv
// Mode register with deferred apply: staged write lands once both ports idle.
module hma_mode (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] sel_i,
  input  logic       idle_i,
  output logic [1:0] mode_o,
  output logic       hold_o
);
  logic [1:0] mode_q, pend_mode_q;
  logic       pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= 2'b00;
      pend_mode_q <= 2'b00;
      pend_q      <= 1'b0;
    end else if (we_i) begin
      pend_q      <= 1'b1;
      pend_mode_q <= sel_i;
    end else if (pend_q && idle_i) begin
      mode_q      <= pend_mode_q;
      pend_q      <= 1'b0;
    end
  end

  assign mode_o = mode_q;
  assign hold_o = pend_q;
endmodule

// File: rtl/host_access_arbiter.sv
module host_access_arbiter
  import hma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_req_i,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  output logic          host_ready_o,
  output logic          host_err_o,
  input  logic          dsp_req_i,
  input  logic          dsp_we_i,
  input  logic [AW-1:0] dsp_addr_i,
  input  logic [DW-1:0] dsp_wdata_i,
  output logic [DW-1:0] dsp_rdata_o,
  output logic          dsp_ready_o,
  input  logic          mode_we_i,
  input  logic [1:0]    mode_wdata_i,
  output logic [1:0]    mode_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_region_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ack_i,
  output logic          per_req_o,
  output logic          per_we_o,
  output logic [AW-1:0] per_addr_o,
  output logic [DW-1:0] per_wdata_o,
  input  logic [DW-1:0] per_rdata_i,
  input  logic          per_ack_i
);
  localparam int PER_BIT = AW - 1;
  localparam int RGN_HI  = AW - 2;
  localparam int RGN_LO  = AW - 3;

  logic    hom_mem, hom_per, mode_hold, idle;
  logic    h_is_per, d_is_per;
  region_e h_rgn, d_rgn;
  logic    h_mem_req, h_per_req, d_mem_req, d_per_req, h_bad, herr_q;
  logic    h_mem_done, d_mem_done, h_per_done, d_per_done;
  logic    mem_busy, per_busy;
  owner_e  mem_owner, per_owner;

  assign h_is_per = host_addr_i[PER_BIT];
  assign d_is_per = dsp_addr_i[PER_BIT];
  assign h_rgn    = rgn_of(host_addr_i[RGN_HI:RGN_LO]);
  assign d_rgn    = rgn_of(dsp_addr_i[RGN_HI:RGN_LO]);
  assign {hom_mem, hom_per} = mode_o;

  // eligibility per mode; ineligible DSP requests simply stall
  assign h_mem_req = host_req_i && !h_is_per && (!hom_mem || h_rgn == RGN_SARAM);
  assign h_per_req = host_req_i && h_is_per;
  assign d_mem_req = dsp_req_i && !d_is_per && !(hom_mem && d_rgn == RGN_SARAM);
  assign d_per_req = dsp_req_i && d_is_per && !hom_per;
  assign h_bad     = host_req_i && !h_is_per && hom_mem && (h_rgn != RGN_SARAM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) herr_q <= 1'b0;
    else         herr_q <= h_bad && !herr_q && !mode_hold;
  end

  hma_mode u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mode_we_i),
    .sel_i  (mode_wdata_i),
    .idle_i (idle),
    .mode_o (mode_o),
    .hold_o (mode_hold)
  );

  hma_slot #(.AW(AW), .DW(DW)) u_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_i      (mode_hold),
    .h_req_i     (h_mem_req),
    .h_we_i      (host_we_i),
    .h_addr_i    (host_addr_i),
    .h_wdata_i   (host_wdata_i),
    .d_req_i     (d_mem_req),
    .d_we_i      (dsp_we_i),
    .d_addr_i    (dsp_addr_i),
    .d_wdata_i   (dsp_wdata_i),
    .tgt_req_o   (mem_req_o),
    .tgt_we_o    (mem_we_o),
    .tgt_addr_o  (mem_addr_o),
    .tgt_wdata_o (mem_wdata_o),
    .tgt_ack_i   (mem_ack_i),
    .h_done_o    (h_mem_done),
    .d_done_o    (d_mem_done),
    .busy_o      (mem_busy),
    .owner_o     (mem_owner)
  );

  hma_slot #(.AW(AW), .DW(DW)) u_per (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_i      (mode_hold),
    .h_req_i     (h_per_req),
    .h_we_i      (host_we_i),
    .h_addr_i    (host_addr_i),
    .h_wdata_i   (host_wdata_i),
    .d_req_i     (d_per_req),
    .d_we_i      (dsp_we_i),
    .d_addr_i    (dsp_addr_i),
    .d_wdata_i   (dsp_wdata_i),
    .tgt_req_o   (per_req_o),
    .tgt_we_o    (per_we_o),
    .tgt_addr_o  (per_addr_o),
    .tgt_wdata_o (per_wdata_o),
    .tgt_ack_i   (per_ack_i),
    .h_done_o    (h_per_done),
    .d_done_o    (d_per_done),
    .busy_o      (per_busy),
    .owner_o     (per_owner)
  );

  assign idle         = !mem_busy && !per_busy;
  assign mem_region_o = rgn_of(mem_addr_o[RGN_HI:RGN_LO]);

  assign host_ready_o = herr_q || h_mem_done || h_per_done;
  assign host_err_o   = herr_q;
  assign dsp_ready_o  = d_mem_done || d_per_done;

  always_comb begin
    if (h_per_done)      host_rdata_o = per_rdata_i;
    else if (h_mem_done) host_rdata_o = mem_rdata_i;
    else                 host_rdata_o = '0;
    if (d_per_done)      dsp_rdata_o  = per_rdata_i;
    else if (d_mem_done) dsp_rdata_o  = mem_rdata_i;
    else                 dsp_rdata_o  = '0;
  end
endmodule

// File: rtl/host_access_arbiter_chk.sv
module host_access_arbiter_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    mode_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [1:0]    mem_region_o,
  input logic          mem_ack_i,
  input logic          per_req_o,
  input logic          host_ready_o,
  input logic          host_err_o,
  input logic          mem_owner,
  input logic          per_owner
);
  // R2: target request held with stable fields until ack
  a_r2_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  // R2: ack ends the access, no back-to-back regrant
  a_r2_ack_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> !mem_req_o);

  // R6: error response is a single ready cycle
  a_r6_err_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_err_o |-> host_ready_o);
  a_r6_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_err_o |=> !host_err_o);

  // R5: SARAM belongs to the host in host-only memory mode
  a_r5_saram_host: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[1] && mem_req_o && mem_region_o == 2'd0 |-> mem_owner == 1'b0);

  // R7: peripheral port belongs to the host in host-only peripheral mode
  a_r7_per_host: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[0] && per_req_o |-> per_owner == 1'b0);

  // R8: mode changes only across idle cycles
  a_r8_mode_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != $past(mode_o) |-> !$past(mem_req_o) && !$past(per_req_o) && !mem_req_o && !per_req_o);
endmodule

bind host_access_arbiter host_access_arbiter_chk #(.AW(AW)) u_chk (.*);

// File: tb/host_access_arbiter_test.sv
`timescale 1ns/1ps
module host_access_arbiter_test;
  localparam int AW = 16, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          h_req = 0, h_we = 0, d_req = 0, d_we = 0, m_we = 0;
  logic [AW-1:0] h_addr = 0, d_addr = 0;
  logic [DW-1:0] h_wd = 0, d_wd = 0, h_rd, d_rd;
  logic          h_rdy, h_err, d_rdy;
  logic [1:0]    m_sel = 0, mode;
  logic          mem_req, mem_we, mem_ack = 0, per_req, per_we, per_ack = 0;
  logic [AW-1:0] mem_addr, per_addr;
  logic [1:0]    mem_rgn;
  logic [DW-1:0] mem_wd, mem_rd, per_wd, per_rd;

  host_access_arbiter #(.AW(AW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_req_i(h_req), .host_we_i(h_we), .host_addr_i(h_addr), .host_wdata_i(h_wd),
    .host_rdata_o(h_rd), .host_ready_o(h_rdy), .host_err_o(h_err),
    .dsp_req_i(d_req), .dsp_we_i(d_we), .dsp_addr_i(d_addr), .dsp_wdata_i(d_wd),
    .dsp_rdata_o(d_rd), .dsp_ready_o(d_rdy),
    .mode_we_i(m_we), .mode_wdata_i(m_sel), .mode_o(mode),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_region_o(mem_rgn),
    .mem_wdata_o(mem_wd), .mem_rdata_i(mem_rd), .mem_ack_i(mem_ack),
    .per_req_o(per_req), .per_we_o(per_we), .per_addr_o(per_addr), .per_wdata_o(per_wd),
    .per_rdata_i(per_rd), .per_ack_i(per_ack)
  );

  // target models: 0 = immediate ack, 1 = random, 2 = never
  int mem_mode = 0, per_mode = 0;
  logic [DW-1:0] mem_model [64];
  logic [DW-1:0] per_model [16];
  logic [DW-1:0] exp_mem [64];
  logic [DW-1:0] exp_per [16];
  int mem_cycles = 0;
  logic [1:0] last_rgn = 0;

  assign mem_rd = mem_model[{mem_rgn, mem_addr[3:0]}];
  assign per_rd = per_model[per_addr[3:0]];

  always @(posedge clk) begin
    #2;
    mem_ack = mem_req && (mem_mode == 0 || (mem_mode == 1 && $urandom % 2 == 1));
    per_ack = per_req && (per_mode == 0 || (per_mode == 1 && $urandom % 2 == 1));
  end
  always @(posedge clk) begin
    if (mem_req) mem_cycles <= mem_cycles + 1;
    if (mem_req && mem_ack) last_rgn <= mem_rgn;
    if (mem_req && mem_ack && mem_we) mem_model[{mem_rgn, mem_addr[3:0]}] <= mem_wd;
    if (per_req && per_ack && per_we) per_model[per_addr[3:0]] <= per_wd;
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_region(input logic [AW-1:0] a);
    return (a[14:13] == 2'b00) ? 2'd0 : (a[14:13] == 2'b01) ? 2'd1 : 2'd2;
  endfunction

  function automatic logic [AW-1:0] mk_addr(input bit per, input logic [1:0] rgn, input logic [3:0] low);
    return per ? {1'b1, 11'b0, low} : {1'b0, rgn, 9'b0, low};
  endfunction

  task automatic host_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd, input int lim,
                         output logic [DW-1:0] rd, output bit err, output bit to, output int lat);
    @(negedge clk);
    h_req = 1; h_we = we; h_addr = a; h_wd = wd; lat = 0; to = 0; err = 0; rd = '0;
    forever begin
      @(negedge clk); lat++;
      if (h_rdy) begin rd = h_rd; err = h_err; break; end
      if (lat >= lim) begin to = 1; break; end
    end
    @(posedge clk); #1 h_req = 0;
  endtask

  task automatic dsp_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd, input int lim,
                        output logic [DW-1:0] rd, output bit to, output int lat);
    @(negedge clk);
    d_req = 1; d_we = we; d_addr = a; d_wd = wd; lat = 0; to = 0; rd = '0;
    forever begin
      @(negedge clk); lat++;
      if (d_rdy) begin rd = d_rd; break; end
      if (lat >= lim) begin to = 1; break; end
    end
    @(posedge clk); #1 d_req = 0;
  endtask

  task automatic set_mode(input logic [1:0] v);
    @(negedge clk); m_we = 1; m_sel = v;
    @(negedge clk); m_we = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [DW-1:0] rd, rd2;
    bit err, to, to2;
    int lat, lat2, snap;
    int unsigned seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < 64; i++) begin mem_model[i] = DW'(16'hA000 + i); exp_mem[i] = DW'(16'hA000 + i); end
    for (int i = 0; i < 16; i++) begin per_model[i] = DW'(16'h5000 + i); exp_per[i] = DW'(16'h5000 + i); end

    repeat (3) @(negedge clk);
    chk(mode == 2'b00 && !h_rdy && !d_rdy && !mem_req && !per_req, "R4", "reset state",
        {mode, h_rdy, d_rdy, mem_req, per_req}, 0);
    rst_n = 1;
    @(negedge clk);

    // R1/R9: one write per region, read back
    foreach (exp_mem[i]) begin end
    begin
      logic [AW-1:0] al [4];
      al[0] = 16'h0003; al[1] = 16'h2005; al[2] = 16'h4007; al[3] = 16'h6009;
      for (int k = 0; k < 4; k++) begin
        host_op(1, al[k], DW'(16'h1100 + k), 50, rd, err, to, lat);
        chk(lat == 1 && !err, "R2", "uncontended latency", lat, 1);
        chk(last_rgn == exp_region(al[k]), "R1", "region code", last_rgn, exp_region(al[k]));
        exp_mem[{exp_region(al[k]), al[k][3:0]}] = DW'(16'h1100 + k);
        dsp_op(0, al[k], 0, 50, rd, to, lat);
        chk(rd == exp_mem[{exp_region(al[k]), al[k][3:0]}], "R9", "memory read back", rd, exp_mem[{exp_region(al[k]), al[k][3:0]}]);
      end
      host_op(1, 16'h8004, 16'hBEEF, 50, rd, err, to, lat);
      exp_per[4] = 16'hBEEF;
      chk(per_model[4] == 16'hBEEF, "R1", "peripheral write landed", per_model[4], 16'hBEEF);
      dsp_op(0, 16'h8004, 0, 50, rd, to, lat);
      chk(rd == 16'hBEEF, "R9", "peripheral read back", rd, 16'hBEEF);
    end

    // R3: first tie goes to host
    fork
      host_op(0, 16'h0001, 0, 50, rd, err, to, lat);
      dsp_op(0, 16'h2001, 0, 50, rd2, to2, lat2);
    join
    chk(lat < lat2, "R3", "first tie host wins", lat, lat2);
    host_op(0, 16'h0002, 0, 50, rd, err, to, lat);
    fork
      host_op(0, 16'h0001, 0, 50, rd, err, to, lat);
      dsp_op(0, 16'h2001, 0, 50, rd2, to2, lat2);
    join
    chk(lat2 < lat, "R3", "tie after host grant goes to dsp", lat2, lat);
    fork
      host_op(0, 16'h8001, 0, 50, rd, err, to, lat);
      dsp_op(0, 16'h8002, 0, 50, rd2, to2, lat2);
    join
    chk(!to && !to2 && rd == exp_per[1] && rd2 == exp_per[2], "R3", "shared peripheral both served", rd2, exp_per[2]);

    // R4 encodings
    set_mode(2'b10); @(negedge clk);
    chk(mode == 2'b10, "R4", "host-only memory code", mode, 2);

    // R6: refused host access, no side effect
    snap = mem_cycles;
    host_op(1, 16'h2005, 16'hDEAD, 50, rd, err, to, lat);
    chk(err && lat == 1, "R6", "daram refused with error", {err, 8'(lat)}, 9'h101);
    host_op(1, 16'h4007, 16'hDEAD, 50, rd, err, to, lat);
    chk(err && lat == 1, "R6", "external refused with error", {err, 8'(lat)}, 9'h101);
    chk(mem_cycles == snap, "R6", "no memory access on error", mem_cycles - snap, 0);
    // R5: dsp keeps DARAM/external, stalls on SARAM
    dsp_op(0, 16'h2005, 0, 50, rd, to, lat);
    chk(!to && rd == exp_mem[{2'd1, 4'd5}], "R6", "daram unchanged after refusal", rd, exp_mem[{2'd1, 4'd5}]);
    dsp_op(0, 16'h0003, 0, 20, rd, to, lat);
    chk(to, "R5", "dsp saram stalled", to, 1);
    host_op(1, 16'h0003, 16'h7777, 50, rd, err, to, lat);
    exp_mem[3] = 16'h7777;
    chk(!err && !to, "R5", "host saram served", {err, to}, 0);

    set_mode(2'b01); @(negedge clk);
    chk(mode == 2'b01, "R4", "host-only peripheral code", mode, 1);
    dsp_op(1, 16'h8006, 16'h1234, 20, rd, to, lat);
    chk(to, "R7", "dsp peripheral stalled", to, 1);
    chk(per_model[6] == exp_per[6], "R7", "stalled write no effect", per_model[6], exp_per[6]);
    host_op(0, 16'h8004, 0, 50, rd, err, to, lat);
    chk(!to && rd == exp_per[4], "R7", "host peripheral served", rd, exp_per[4]);
    dsp_op(0, 16'h0003, 0, 50, rd, to, lat);
    chk(!to && rd == 16'h7777, "R5", "dsp saram back when memory shared", rd, 16'h7777);

    set_mode(2'b11); @(negedge clk);
    chk(mode == 2'b11, "R4", "both exclusive code", mode, 3);
    set_mode(2'b00); @(negedge clk);
    chk(mode == 2'b00, "R4", "shared code", mode, 0);

    // R8: mode write during a stalled access waits for it
    mem_mode = 2;
    fork
      host_op(0, 16'h0003, 0, 200, rd, err, to, lat);
      begin
        repeat (3) @(negedge clk);
        set_mode(2'b10);
        repeat (4) @(negedge clk);
        chk(mode == 2'b00, "R8", "mode held while access in flight", mode, 0);
        mem_mode = 0;
      end
    join
    repeat (2) @(negedge clk);
    chk(mode == 2'b10 && !to && rd == 16'h7777, "R8", "mode applied after access", mode, 2);
    set_mode(2'b00); @(negedge clk);

    // random concurrent traffic, host even offsets, dsp odd
    mem_mode = 1; per_mode = 1;
    fork
      for (int i = 0; i < 60; i++) begin
        bit per = ($urandom % 4 == 0);
        logic [1:0] rg = 2'($urandom);
        logic [3:0] lo = {3'($urandom), 1'b0};
        logic [AW-1:0] a = mk_addr(per, rg, lo);
        bit we = $urandom % 2 == 1;
        logic [DW-1:0] wd = DW'($urandom);
        logic [DW-1:0] r; bit e, t; int l;
        host_op(we, a, wd, 200, r, e, t, l);
        if (we) begin
          if (per) exp_per[lo] = wd; else exp_mem[{exp_region(a), lo}] = wd;
          chk(!t && !e, "R3", "host random write done", {e, t}, 0);
        end else if (per) chk(!t && r == exp_per[lo], "R9", "host random peripheral read", r, exp_per[lo]);
        else chk(!t && r == exp_mem[{exp_region(a), lo}], "R9", "host random memory read", r, exp_mem[{exp_region(a), lo}]);
      end
      for (int i = 0; i < 60; i++) begin
        bit per = ($urandom % 4 == 0);
        logic [1:0] rg = 2'($urandom);
        logic [3:0] lo = {3'($urandom), 1'b1};
        logic [AW-1:0] a = mk_addr(per, rg, lo);
        bit we = $urandom % 2 == 1;
        logic [DW-1:0] wd = DW'($urandom);
        logic [DW-1:0] r; bit t; int l;
        dsp_op(we, a, wd, 200, r, t, l);
        if (we) begin
          if (per) exp_per[lo] = wd; else exp_mem[{exp_region(a), lo}] = wd;
          chk(!t, "R3", "dsp random write done", t, 0);
        end else if (per) chk(!t && r == exp_per[lo], "R9", "dsp random peripheral read", r, exp_per[lo]);
        else chk(!t && r == exp_mem[{exp_region(a), lo}], "R9", "dsp random memory read", r, exp_mem[{exp_region(a), lo}]);
      end
    join

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule